// File: doc/BRIEF.md
# Block Transfer Byte Packer

This engine moves data for a multi-block card transfer between a 16-bit word buffer and a byte-wide card data port. In the card-to-buffer direction it collects card bytes into words, low half first. In the buffer-to-card direction it splits each buffer word into bytes, low byte first. It moves one byte per clock. A half-word holding register keeps the first half of the word until the second half is ready.

Two programmable registers set the bytes per block and the blocks per transfer. Each stored value is the written 11-bit field plus one. Live down-counters track progress and reload themselves. A block with an odd length ends with a lone byte. In the read direction that byte goes into a word whose high half is zero. In the write direction the high half of the last word is dropped. The next block always starts a fresh word. A start pulse begins a transfer, flushes the buffer and latches the direction. The done flag rises when the last byte of the last block has moved. Buffer storage, card framing and CRC sit outside this block.

Top module: `blk_xfer_packer`

## Requirements
- R1: After reset both live counters read 1, `busy_o` and `done_o` are low, and no card or buffer strobe is active.
- R2: A length write (`blen_wr_i`) stores `cfg_val_i + 1` and loads the live byte counter with it. A count write (`nblk_wr_i`) stores `cfg_val_i + 1` in the block register and live block counter, and reloads the live byte counter from the stored length. The live counters are visible on `blen_cnt_o` and `nblk_cnt_o` on the cycle after the write.
- R3: In the read direction (`dir_rd_i` = 1 at start), the engine takes one card byte per cycle on `card_rd_o`. The first byte of a word fills bits 7:0 and the next byte fills bits 15:8. The word is pushed once complete. A block's odd final byte is pushed alone with bits 15:8 zero.
- R4: In the write direction (`dir_rd_i` = 0 at start), the engine pops the head word and sends bits 7:0 first. It then sends bits 15:8 on the next step, but only if the current block still has bytes left. Otherwise the high half is discarded.
- R5: In the read direction, no new word is started while `buf_count_i` exceeds `af_level_i`. A word already started always completes.
- R6: In the write direction, no new word is started while `buf_count_i` is zero.
- R7: Each moved byte decrements the live byte counter. When it passes its last byte, the counter reloads the stored length and the live block counter decrements. The next block starts with a new word.
- R8: When the last byte of the last block moves, the block counter reloads the stored count and `busy_o` falls. `done_o` then stays high until the next start or until enable is cleared.
- R9: A start pulse while enabled asserts `buf_flush_o`, latches the direction, sets `busy_o` and clears `done_o`. A start pulse while disabled leaves `busy_o` low.
- R10: While `enable_i` is low, `buf_flush_o` is high, `busy_o` and `done_o` are forced low, and no strobes are issued. The live counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable; low aborts and flushes |
| blen_wr_i | input | 1 | Write strobe for the block length register |
| nblk_wr_i | input | 1 | Write strobe for the block count register |
| cfg_val_i | input | LEN_W | Programmed value minus one |
| start_i | input | 1 | Start pulse for a data command |
| dir_rd_i | input | 1 | Direction at start: 1 card to buffer, 0 buffer to card |
| buf_count_i | input | OCC_W | Buffer occupancy in words |
| buf_head_i | input | 16 | Word at the buffer head |
| af_level_i | input | LVL_W | Almost-full level |
| card_rd_data_i | input | 8 | Card byte offered to the engine |
| card_rd_o | output | 1 | Takes `card_rd_data_i` this cycle |
| card_wr_o | output | 1 | Sends `card_wr_data_o` this cycle |
| card_wr_data_o | output | 8 | Byte sent to the card |
| buf_push_o | output | 1 | Pushes `buf_push_data_o` into the buffer |
| buf_push_data_o | output | 16 | Assembled word |
| buf_pop_o | output | 1 | Removes the buffer head word |
| buf_flush_o | output | 1 | Clears buffer indexes and occupancy |
| blen_cnt_o | output | LEN_W+1 | Live byte counter |
| nblk_cnt_o | output | LEN_W+1 | Live block counter |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer-done status |

## Verification
The assertions check the following on every cycle:
- the flow-control pauses in both directions;
- that an idle or disabled engine issues no strobe;
- that each live counter stays between one and its stored value;
- that a push and a pop never coincide;
- that `done_o` only rises as `busy_o` falls.

The byte order inside each word, the zero high half and the dropped high byte at odd block ends, and the byte stream across block boundaries can only be shown by the bench. It sweeps every length from 1 to 8 against counts of 1 to 3 in both directions and compares the buffer contents or the card byte log with sequences it computes itself. The counter reload on a count write and the exact counter values at a flow-control stall are also checked only by scenario.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } half_e;
endpackage

// File: rtl/blk_reload_counter.sv
module blk_reload_counter #(
  parameter int unsigned LEN_W = 11,
  localparam int unsigned CW = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [LEN_W-1:0] cfg_val_i,
  input  logic             reload_i,
  input  logic             dec_i,
  output logic [CW-1:0]    cnt_o,
  output logic             last_o
);
  logic [CW-1:0] stored_q, cnt_q, cfg_ext;

  assign cfg_ext = {1'b0, cfg_val_i} + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= CW'(1);
      cnt_q    <= CW'(1);
    end else if (cfg_wr_i) begin
      stored_q <= cfg_ext;
      cnt_q    <= cfg_ext;
    end else if (reload_i) begin
      cnt_q <= stored_q;
    end else if (dec_i) begin
      cnt_q <= last_o ? stored_q : cnt_q - CW'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(1));

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && (cnt_q <= stored_q)); // R2
endmodule

// File: rtl/blk_pack_unit.sv
module blk_pack_unit
  import blk_xfer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        step_i,
  input  xfer_dir_e   dir_i,
  input  logic        last_i,
  input  logic [7:0]  card_rd_data_i,
  input  logic [15:0] buf_head_i,
  output half_e       half_o,
  output logic        card_rd_o,
  output logic        card_wr_o,
  output logic [7:0]  card_wr_data_o,
  output logic        buf_push_o,
  output logic [15:0] buf_push_data_o,
  output logic        buf_pop_o
);
  half_e      half_q;
  logic [7:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= PH_LO;
      hold_q <= '0;
    end else if (clear_i) begin
      half_q <= PH_LO;
      hold_q <= '0;
    end else if (step_i) begin
      // block end always restarts on a fresh word
      half_q <= (last_i || half_q == PH_HI) ? PH_LO : PH_HI;
      if (half_q == PH_LO)
        hold_q <= (dir_i == XFER_RD) ? card_rd_data_i : buf_head_i[15:8];
    end
  end

  assign half_o          = half_q;
  assign card_rd_o       = step_i && dir_i == XFER_RD;
  assign card_wr_o       = step_i && dir_i == XFER_WR;
  assign card_wr_data_o  = (half_q == PH_HI) ? hold_q : buf_head_i[7:0];
  assign buf_push_o      = card_rd_o && (half_q == PH_HI || last_i);
  assign buf_push_data_o = (half_q == PH_HI) ? {card_rd_data_i, hold_q}
                                             : {8'h00, card_rd_data_i};
  assign buf_pop_o       = card_wr_o && half_q == PH_LO;

  AST_PUSH_POP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_push_o && buf_pop_o)); // R3
endmodule

// File: rtl/blk_xfer_packer.sv
module blk_xfer_packer
  import blk_xfer_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned OCC_W = 6,
  parameter int unsigned LVL_W = 5,
  localparam int unsigned CW = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             blen_wr_i,
  input  logic             nblk_wr_i,
  input  logic [LEN_W-1:0] cfg_val_i,
  input  logic             start_i,
  input  logic             dir_rd_i,
  input  logic [OCC_W-1:0] buf_count_i,
  input  logic [15:0]      buf_head_i,
  input  logic [LVL_W-1:0] af_level_i,
  input  logic [7:0]       card_rd_data_i,
  output logic             card_rd_o,
  output logic             card_wr_o,
  output logic [7:0]       card_wr_data_o,
  output logic             buf_push_o,
  output logic [15:0]      buf_push_data_o,
  output logic             buf_pop_o,
  output logic             buf_flush_o,
  output logic [CW-1:0]    blen_cnt_o,
  output logic [CW-1:0]    nblk_cnt_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned PAD_W = OCC_W - LVL_W;

  logic      active_q, done_q;
  xfer_dir_e dir_q;
  half_e     half;
  logic      byte_last, blk_last, room_ok, step, blk_dec, xfer_end;
  logic [OCC_W-1:0] af_ext;

  assign af_ext  = {{PAD_W{1'b0}}, af_level_i};
  assign room_ok = (dir_q == XFER_RD) ? (buf_count_i <= af_ext)
                                      : (buf_count_i != '0);
  // second half of a started word never waits
  assign step     = active_q && enable_i && (half == PH_HI || room_ok);
  assign blk_dec  = step && byte_last;
  assign xfer_end = blk_dec && blk_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      dir_q    <= XFER_WR;
    end else if (!enable_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      dir_q    <= dir_rd_i ? XFER_RD : XFER_WR;
    end else if (xfer_end) begin
      active_q <= 1'b0;
      done_q   <= 1'b1;
    end
  end

  blk_reload_counter #(.LEN_W(LEN_W)) u_byte_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (blen_wr_i),
    .cfg_val_i (cfg_val_i),
    .reload_i  (nblk_wr_i),
    .dec_i     (step),
    .cnt_o     (blen_cnt_o),
    .last_o    (byte_last)
  );

  blk_reload_counter #(.LEN_W(LEN_W)) u_blk_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (nblk_wr_i),
    .cfg_val_i (cfg_val_i),
    .reload_i  (1'b0),
    .dec_i     (blk_dec),
    .cnt_o     (nblk_cnt_o),
    .last_o    (blk_last)
  );

  blk_pack_unit u_pack (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clear_i         (buf_flush_o),
    .step_i          (step),
    .dir_i           (dir_q),
    .last_i          (byte_last),
    .card_rd_data_i  (card_rd_data_i),
    .buf_head_i      (buf_head_i),
    .half_o          (half),
    .card_rd_o       (card_rd_o),
    .card_wr_o       (card_wr_o),
    .card_wr_data_o  (card_wr_data_o),
    .buf_push_o      (buf_push_o),
    .buf_push_data_o (buf_push_data_o),
    .buf_pop_o       (buf_pop_o)
  );

  assign buf_flush_o = !enable_i || start_i;
  assign busy_o      = active_q;
  assign done_o      = done_q;

  AST_RD_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == XFER_RD && half == PH_LO && buf_count_i > af_ext) |-> !card_rd_o); // R5
  AST_WR_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == XFER_WR && half == PH_LO && buf_count_i == '0) |-> !card_wr_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || !enable_i) |-> !(card_rd_o || card_wr_o || buf_push_o || buf_pop_o)); // R10
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy_o && !done_o)); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o); // R8
  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && enable_i) |=> (busy_o && !done_o)); // R9
endmodule

// File: tb/blk_xfer_packer_bench.sv
module blk_xfer_packer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        enable = 1'b0, blen_wr = 1'b0, nblk_wr = 1'b0, start = 1'b0, dir_rd = 1'b0;
  logic [10:0] cfg_val = '0;
  logic [4:0]  af_level = 5'd31;
  logic        card_rd, card_wr, buf_push, buf_pop, buf_flush, busy, done;
  logic [7:0]  card_wr_data, card_rd_data;
  logic [15:0] push_data, buf_head;
  logic [11:0] blen_cnt, nblk_cnt;
  logic [5:0]  buf_count;

  logic        host_push = 1'b0, host_pop = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] fifo [32];
  int rp = 0, wp = 0, cnt = 0, src_seq = 0, wr_n = 0;
  logic [7:0] wr_log [512];
  int checks = 0, fails = 0;
  bit finished = 0;

  assign buf_count    = 6'(cnt);
  assign buf_head     = fifo[rp];
  assign card_rd_data = 8'(src_seq);

  blk_xfer_packer u_blk_xfer_packer (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .blen_wr_i(blen_wr),
    .nblk_wr_i(nblk_wr), .cfg_val_i(cfg_val), .start_i(start), .dir_rd_i(dir_rd),
    .buf_count_i(buf_count), .buf_head_i(buf_head), .af_level_i(af_level),
    .card_rd_data_i(card_rd_data), .card_rd_o(card_rd), .card_wr_o(card_wr),
    .card_wr_data_o(card_wr_data), .buf_push_o(buf_push), .buf_push_data_o(push_data),
    .buf_pop_o(buf_pop), .buf_flush_o(buf_flush), .blen_cnt_o(blen_cnt),
    .nblk_cnt_o(nblk_cnt), .busy_o(busy), .done_o(done)
  );

  // buffer and card models
  always @(posedge clk) begin
    if (buf_flush) begin
      rp <= 0; wp <= 0; cnt <= 0;
    end else begin
      automatic bit do_pop  = (buf_pop || host_pop) && cnt > 0;
      automatic bit do_push = buf_push || host_push;
      if (do_push) begin
        fifo[wp] <= buf_push ? push_data : host_wdata;
        wp <= (wp + 1) % 32;
      end
      if (do_pop) rp <= (rp + 1) % 32;
      cnt <= cnt + int'(do_push) - int'(do_pop);
    end
    if (card_rd) src_seq <= src_seq + 1;
    if (card_wr) begin
      wr_log[wr_n % 512] <= card_wr_data;
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic cfg(int l, int n);
    @(negedge clk); blen_wr = 1; cfg_val = 11'(l - 1);
    @(negedge clk); blen_wr = 0; nblk_wr = 1; cfg_val = 11'(n - 1);
    @(negedge clk); nblk_wr = 0;
  endtask

  task automatic go(bit rd);
    @(negedge clk); start = 1; dir_rd = rd;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(string req);
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen, req, "done_reached", int'(seen), 1);
  endtask

  task automatic run_read(int l, int n);
    int base, k, idx;
    cfg(l, n);
    af_level = 5'd31;
    base = src_seq;
    go(1);
    wait_done("R8");
    chk(!busy, "R8", "busy_after_done", busy, 0);
    chk(blen_cnt == 12'(l) && nblk_cnt == 12'(n), "R8", "counters_reloaded",
        int'(blen_cnt) * 4096 + int'(nblk_cnt), l * 4096 + n);
    chk(src_seq - base == l * n, "R3", "bytes_taken", src_seq - base, l * n);
    chk(cnt == n * ((l + 1) / 2), "R3", "words_pushed", cnt, n * ((l + 1) / 2));
    k = base; idx = 0;
    for (int b = 0; b < n; b++) begin
      for (int j = 0; j < l; j += 2) begin
        logic [15:0] exp;
        exp[7:0]  = 8'(k);
        exp[15:8] = (j + 1 < l) ? 8'(k + 1) : 8'h00;
        k += (j + 1 < l) ? 2 : 1;
        chk(fifo[idx % 32] === exp, (l % 2 == 1) ? "R7" : "R3", "read_word",
            int'(fifo[idx % 32]), int'(exp));
        idx++;
      end
    end
  endtask

  task automatic run_write(int l, int n);
    int base, w, i;
    cfg(l, n);
    w = n * ((l + 1) / 2);
    go(0);
    base = wr_n;
    repeat (3) @(negedge clk);
    chk(wr_n == base && busy, "R6", "stall_on_empty", wr_n - base, 0);
    for (int p = 0; p < w; p++) begin
      host_push = 1; host_wdata = {8'(8'h80 + p), 8'(8'h40 + p)};
      @(negedge clk);
    end
    host_push = 0;
    wait_done("R8");
    chk(wr_n - base == l * n, "R4", "bytes_sent", wr_n - base, l * n);
    chk(cnt == 0, "R4", "words_popped", cnt, 0);
    i = 0; w = base;
    for (int b = 0; b < n; b++) begin
      for (int j = 0; j < l; j += 2) begin
        chk(wr_log[w % 512] == 8'(8'h40 + i), "R4", "low_byte",
            int'(wr_log[w % 512]), 8'h40 + i);
        w++;
        if (j + 1 < l) begin
          chk(wr_log[w % 512] == 8'(8'h80 + i), "R4", "high_byte",
              int'(wr_log[w % 512]), 8'h80 + i);
          w++;
        end
        i++;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(blen_cnt == 1 && nblk_cnt == 1, "R1", "reset_counters", int'(blen_cnt), 1);
    chk(!busy && !done, "R1", "reset_flags", int'({busy, done}), 0);
    chk(!(card_rd || card_wr || buf_push || buf_pop), "R1", "reset_strobes",
        int'({card_rd, card_wr, buf_push, buf_pop}), 0);
    enable = 1;

    // R2: value plus one, live counters
    cfg(2048, 6);
    chk(blen_cnt == 12'd2048, "R2", "blen_max", int'(blen_cnt), 2048);
    chk(nblk_cnt == 12'd6, "R2", "nblk_val", int'(nblk_cnt), 6);

    for (int l = 1; l <= 8; l++)
      for (int n = 1; n <= 3; n++) begin
        run_read(l, n);
        run_write(l, n);
      end

    // R9: start clears done, flushes
    run_read(3, 1);
    go(0);
    chk(!done && busy && cnt == 0, "R9", "start_clears",
        int'({done, busy}) * 64 + cnt, 1 * 64);
    @(negedge clk); enable = 0; @(negedge clk); enable = 1;

    // R5, R7: almost-full pause and block rollover
    cfg(8, 2);
    af_level = 5'd2;
    go(1);
    repeat (15) @(negedge clk);
    chk(cnt == 3 && busy, "R5", "paused_occupancy", cnt, 3);
    chk(blen_cnt == 12'd2, "R7", "live_bytes_at_pause", int'(blen_cnt), 2);
    chk(nblk_cnt == 12'd2, "R7", "live_blocks_at_pause", int'(nblk_cnt), 2);
    host_pop = 1; @(negedge clk); host_pop = 0;
    repeat (6) @(negedge clk);
    chk(cnt == 3, "R5", "resume_one_word", cnt, 3);
    chk(blen_cnt == 12'd8 && nblk_cnt == 12'd1, "R7", "block_rollover",
        int'(blen_cnt) * 4096 + int'(nblk_cnt), 8 * 4096 + 1);
    for (int p = 0; p < 10; p++) begin
      host_pop = 1; @(negedge clk); host_pop = 0;
      repeat (3) @(negedge clk);
    end
    wait_done("R8");

    // R10: abort, then R2 reload through count write, R9 ignored start
    cfg(100, 1);
    af_level = 5'd31;
    go(1);
    repeat (20) @(negedge clk);
    chk(busy, "R10", "busy_before_abort", busy, 1);
    enable = 0;
    @(negedge clk);
    chk(!busy && !done && cnt == 0, "R10", "abort_flush",
        int'({busy, done}) * 64 + cnt, 0);
    chk(blen_cnt != 12'd100, "R10", "counter_kept", int'(blen_cnt), 0);
    go(1);
    chk(!busy, "R9", "start_ignored_disabled", busy, 0);
    @(negedge clk); nblk_wr = 1; cfg_val = 11'd0;
    @(negedge clk); nblk_wr = 0;
    chk(blen_cnt == 12'd100 && nblk_cnt == 12'd1, "R2", "count_write_reloads",
        int'(blen_cnt), 100);
    enable = 1;
    @(negedge clk);
    summary();
  end
endmodule